// File: doc/BRIEF.md
# Protection Descriptor Table Loader

This block builds a table of memory-protection region descriptors from a 512-byte configuration row. After a `start` pulse it reads the row one byte at a time through a synchronous read port with one cycle of latency. It assembles little-endian 32-bit words and walks a variable-length layout. The layout is a total-length header followed by three object classes in a fixed order: flash-write, fuse-read and fuse-write. Each class has a 4-byte object count followed by that many 16-byte descriptors.

Each decoded descriptor goes into a register file. The index of an entry is a global object ID that starts at 0 and counts across the classes in load order. When the walk ends, the block raises `done` or raises `error` with a cause code. Downstream protection logic reads the table through a combinational lookup port. A lookup reports an entry as valid only after a parse has completed without error.

Top module: `prot_table_loader`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `rd_req` are 0, `err_code` is 0, and every lookup returns `lk_valid` = 0.
- R2: Each read request is a single-cycle `rd_req` pulse. Addresses run 0, 1, 2 and upward, one byte per request, and the design samples `rd_data` in the cycle after the request. The design issues no request past the last byte it needs (the end of the structure, or the word that raised an error).
- R3: Every 32-bit field is little-endian, with the lowest address holding bits 7:0. The four words of a descriptor are region address, size word, slave attributes and master attributes, in that order. Bit 31 of the size word appears as `lk_en`, and bits 30:0 appear as `lk_size`.
- R4: Global IDs are assigned contiguously from 0. All flash-write objects come first, then the fuse-read objects, then the fuse-write objects. `lk_cls` gives the class: 0 for flash-write, 1 for fuse-read, 2 for fuse-write.
- R5: A class count of zero is legal. Such a class adds no entries, and the parse continues with the next count word.
- R6: If a class count exceeds that class's capacity (16 flash-write, 4 fuse-read, 4 fuse-write), the parse stops with `error` = 1 and `err_code` = 1. A count equal to the capacity is accepted.
- R7: If a flash-write address word has a nonzero bit 1 or bit 0, the parse stops with `error` = 1 and `err_code` = 2. Fuse-class offsets may have any alignment.
- R8: When the last class ends, `done` is raised only if the header length equals the number of bytes consumed. Otherwise `error` = 1 and `err_code` = 3. `done` and `error` are never high together.
- R9: `lk_valid` is 1 only when `done` is high and `lk_id` is below the number of loaded objects. It is 0 throughout a parse and after an error.
- R10: A `start` pulse while `busy` has no effect. A `start` pulse after completion clears the table and flags and begins a fresh read at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a parse (ignored while busy) |
| rd_req | output | 1 | Byte read request, one cycle |
| rd_addr | output | 9 | Byte address of the request |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Parse in progress |
| done | output | 1 | Parse finished successfully |
| error | output | 1 | Parse aborted |
| err_code | output | 2 | 0 none, 1 count over capacity, 2 misaligned, 3 length mismatch |
| lk_id | input | 5 | Global object ID to look up |
| lk_valid | output | 1 | Looked-up entry is loaded and usable |
| lk_cls | output | 2 | Class of the entry |
| lk_addr | output | 32 | Region address or offset |
| lk_en | output | 1 | Region enable flag |
| lk_size | output | 31 | Region size |
| lk_sattr | output | 32 | Slave attribute word |
| lk_mattr | output | 32 | Master attribute word |

## Verification
The hardest state to reach is a completely full table: 24 descriptors with every class at its capacity, which means exactly 400 bytes must be read in order. The bench produces it by generating the row image procedurally, giving each descriptor field a distinct value derived from its global ID. Any byte swap, an off-by-one ID, or a skipped word then shows up as a field mismatch. Abort paths are reached with images that have a count just above capacity, a misaligned address in the second flash-write object, and a header that is off by one byte. A second `start` issued in the middle of a parse must leave the address sequence unbroken.

// File: rtl/prot_ldr_pkg.sv
package prot_ldr_pkg;
   typedef enum logic [1:0] {
      CLS_FW  = 2'd0,
      CLS_FR  = 2'd1,
      CLS_FWR = 2'd2
   } cls_e;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_CAP   = 2'd1,
      ERR_ALIGN = 2'd2,
      ERR_LEN   = 2'd3
   } err_e;

   typedef struct packed {
      logic [31:0] addr;
      logic        en;
      logic [30:0] size;
      logic [31:0] sattr;
      logic [31:0] mattr;
      cls_e        cls;
   } desc_t;
endpackage

// File: rtl/pl_byte_fetch.sv
module pl_byte_fetch #(
   parameter int ROW_BYTES = 512,
   localparam int AW = $clog2(ROW_BYTES),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          word_vld,
   output logic [31:0]   word,
   output logic [CW-1:0] nbytes
);
   logic [1:0]    ph;
   logic [1:0]    bidx;
   logic [31:0]   sr;
   logic [CW-1:0] ptr;

   generate
      if (ROW_BYTES < 16 || (1 << AW) != ROW_BYTES) begin : g_bad_row
         $error("ROW_BYTES must be a power of two of at least 16");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= 2'd0;
         bidx     <= 2'd0;
         sr       <= '0;
         ptr      <= '0;
         rd_req   <= 1'b0;
         rd_addr  <= '0;
         word_vld <= 1'b0;
      end else if (clr) begin
         ph       <= 2'd0;
         bidx     <= 2'd0;
         ptr      <= '0;
         rd_req   <= 1'b0;
         word_vld <= 1'b0;
      end else begin
         rd_req   <= 1'b0;
         word_vld <= 1'b0;
         case (ph)
            2'd0: if (run && !word_vld) begin
               rd_req  <= 1'b1;
               rd_addr <= ptr[AW-1:0];
               ph      <= 2'd1;
            end
            2'd1: ph <= 2'd2;
            2'd2: begin
               sr   <= {rd_data, sr[31:8]};
               bidx <= bidx + 2'd1;
               ptr  <= ptr + 1'b1;
               ph   <= 2'd0;
               if (bidx == 2'd3) word_vld <= 1'b1;
            end
            default: ph <= 2'd0;
         endcase
      end
   end

   assign word   = sr;
   assign nbytes = ptr;

   // R2: requests are isolated single-cycle pulses
   p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
   // R2: a completed word is announced for exactly one cycle
   p_word_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);
endmodule

// File: rtl/pl_parser.sv
module pl_parser
   import prot_ldr_pkg::*;
#(
   parameter int FW_CAP  = 16,
   parameter int FR_CAP  = 4,
   parameter int WR_CAP  = 4,
   parameter int CW      = 10,
   localparam int TOT    = FW_CAP + FR_CAP + WR_CAP,
   localparam int ID_W   = $clog2(TOT),
   localparam int MAXC   = (FW_CAP > FR_CAP) ? ((FW_CAP > WR_CAP) ? FW_CAP : WR_CAP)
                                             : ((FR_CAP > WR_CAP) ? FR_CAP : WR_CAP),
   localparam int OBJ_W  = $clog2(MAXC + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            word_vld,
   input  logic [31:0]     word,
   input  logic [CW-1:0]   nbytes,
   output logic            run,
   output logic            clr,
   output logic            busy,
   output logic            done,
   output logic            error,
   output err_e            err_code,
   output logic            wr_en,
   output logic [ID_W-1:0] wr_id,
   output desc_t           wr_desc
);
   typedef enum logic [1:0] {ST_IDLE, ST_LEN, ST_CNT, ST_DESC} st_e;

   st_e              st;
   cls_e             cls;
   logic [31:0]      hdr_len;
   logic [OBJ_W-1:0] cnt;
   logic [OBJ_W-1:0] obj;
   logic [1:0]       widx;
   logic [ID_W-1:0]  gid;
   logic [31:0]      stg_addr, stg_size, stg_sattr;
   logic             accept, cap_ok, last_obj, leave, len_ok;

   generate
      if (FW_CAP < 1 || FR_CAP < 1 || WR_CAP < 1) begin : g_bad_cap
         $error("each class capacity must be at least one");
      end
      if (16 + 16 * TOT > (1 << (CW - 1))) begin : g_bad_fit
         $error("a full table does not fit in the row");
      end
   endgenerate

   function automatic logic [31:0] cap_of(cls_e c);
      case (c)
         CLS_FW:  return 32'(FW_CAP);
         CLS_FR:  return 32'(FR_CAP);
         default: return 32'(WR_CAP);
      endcase
   endfunction

   always_comb begin
      accept   = start && (st == ST_IDLE);
      cap_ok   = word <= cap_of(cls);
      last_obj = (obj == cnt - 1'b1);
      len_ok   = (32'(nbytes) == hdr_len);
      leave    = word_vld && (((st == ST_CNT) && (word == 32'd0)) ||
                              ((st == ST_DESC) && (widx == 2'd3) && last_obj));
      wr_en    = word_vld && (st == ST_DESC) && (widx == 2'd3);
   end

   assign clr  = accept;
   assign busy = (st != ST_IDLE);
   assign run  = busy;
   assign wr_id = gid;
   assign wr_desc = '{addr: stg_addr, en: stg_size[31], size: stg_size[30:0],
                      sattr: stg_sattr, mattr: word, cls: cls};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cls       <= CLS_FW;
         hdr_len   <= '0;
         cnt       <= '0;
         obj       <= '0;
         widx      <= 2'd0;
         gid       <= '0;
         stg_addr  <= '0;
         stg_size  <= '0;
         stg_sattr <= '0;
         done      <= 1'b0;
         error     <= 1'b0;
         err_code  <= ERR_NONE;
      end else if (accept) begin
         st       <= ST_LEN;
         cls      <= CLS_FW;
         gid      <= '0;
         done     <= 1'b0;
         error    <= 1'b0;
         err_code <= ERR_NONE;
      end else if (word_vld && busy) begin
         case (st)
            ST_LEN: begin
               hdr_len <= word;
               st      <= ST_CNT;
            end
            ST_CNT: begin
               if (!cap_ok) begin
                  error    <= 1'b1;
                  err_code <= ERR_CAP;
                  st       <= ST_IDLE;
               end else begin
                  cnt  <= word[OBJ_W-1:0];
                  obj  <= '0;
                  widx <= 2'd0;
                  st   <= ST_DESC;
               end
            end
            ST_DESC: begin
               widx <= widx + 2'd1;
               case (widx)
                  2'd0: begin
                     if (cls == CLS_FW && word[1:0] != 2'b00) begin
                        error    <= 1'b1;
                        err_code <= ERR_ALIGN;
                        st       <= ST_IDLE;
                     end
                     stg_addr <= word;
                  end
                  2'd1: stg_size  <= word;
                  2'd2: stg_sattr <= word;
                  default: begin
                     gid <= gid + 1'b1;
                     obj <= obj + 1'b1;
                  end
               endcase
            end
            default: st <= ST_IDLE;
         endcase
         if (leave) begin
            if (cls == CLS_FWR) begin
               st <= ST_IDLE;
               if (len_ok) begin
                  done <= 1'b1;
               end else begin
                  error    <= 1'b1;
                  err_code <= ERR_LEN;
               end
            end else begin
               cls <= cls_e'(cls + 2'd1);
               st  <= ST_CNT;
            end
         end
      end
   end

   // R8: success and failure are exclusive
   p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));
   // R8: success implies the consumed byte count matches the header
   p_done_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(nbytes) == hdr_len));
   // R6: an aborted parse always carries a cause
   p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (err_code != ERR_NONE));
   // R4: writes never index past the table
   p_id_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(wr_id) < TOT));
   // R10: a start while busy leaves the parse running
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !word_vld) |=> busy);
endmodule

// File: rtl/pl_desc_table.sv
module pl_desc_table
   import prot_ldr_pkg::*;
#(
   parameter int N = 24,
   localparam int ID_W = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            wr_en,
   input  logic [ID_W-1:0] wr_id,
   input  desc_t           wr_desc,
   input  logic [ID_W-1:0] rd_id,
   output logic            rd_valid,
   output desc_t           rd_desc
);
   logic [N-1:0] vld;
   desc_t        ent [N];

   generate
      if (N < 2) begin : g_bad_n
         $error("table needs at least two entries");
      end
      for (genvar i = 0; i < N; i++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld[i] <= 1'b0;
               ent[i] <= '0;
            end else if (clr) begin
               vld[i] <= 1'b0;
            end else if (wr_en && wr_id == ID_W'(i)) begin
               vld[i] <= 1'b1;
               ent[i] <= wr_desc;
            end
         end
      end
   endgenerate

   always_comb begin
      if (32'(rd_id) < N) begin
         rd_valid = vld[rd_id];
         rd_desc  = ent[rd_id];
      end else begin
         rd_valid = 1'b0;
         rd_desc  = '0;
      end
   end

   // R7: no misaligned flash-write region is ever stored
   p_fw_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_desc.cls == CLS_FW) |-> (wr_desc.addr[1:0] == 2'b00));
   // R10: a new parse starts from an empty table
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vld == '0));
endmodule

// File: rtl/prot_table_loader.sv
module prot_table_loader
   import prot_ldr_pkg::*;
#(
   parameter int ROW_BYTES = 512,
   parameter int FW_CAP    = 16,
   parameter int FR_CAP    = 4,
   parameter int WR_CAP    = 4,
   localparam int AW       = $clog2(ROW_BYTES),
   localparam int CW       = AW + 1,
   localparam int TOT      = FW_CAP + FR_CAP + WR_CAP,
   localparam int ID_W     = $clog2(TOT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic            rd_req,
   output logic [AW-1:0]   rd_addr,
   input  logic [7:0]      rd_data,
   output logic            busy,
   output logic            done,
   output logic            error,
   output logic [1:0]      err_code,
   input  logic [ID_W-1:0] lk_id,
   output logic            lk_valid,
   output logic [1:0]      lk_cls,
   output logic [31:0]     lk_addr,
   output logic            lk_en,
   output logic [30:0]     lk_size,
   output logic [31:0]     lk_sattr,
   output logic [31:0]     lk_mattr
);
   logic            clr, run, word_vld, wr_en, tbl_valid;
   logic [31:0]     word;
   logic [CW-1:0]   nbytes;
   logic [ID_W-1:0] wr_id;
   desc_t           wr_desc, rd_desc;
   err_e            err_q;

   pl_byte_fetch #(.ROW_BYTES(ROW_BYTES)) u_fetch (
      .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .word_vld(word_vld), .word(word), .nbytes(nbytes)
   );

   pl_parser #(.FW_CAP(FW_CAP), .FR_CAP(FR_CAP), .WR_CAP(WR_CAP), .CW(CW)) u_parse (
      .clk(clk), .rst_n(rst_n), .start(start),
      .word_vld(word_vld), .word(word), .nbytes(nbytes),
      .run(run), .clr(clr), .busy(busy), .done(done), .error(error),
      .err_code(err_q), .wr_en(wr_en), .wr_id(wr_id), .wr_desc(wr_desc)
   );

   pl_desc_table #(.N(TOT)) u_tbl (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_en(wr_en), .wr_id(wr_id), .wr_desc(wr_desc),
      .rd_id(lk_id), .rd_valid(tbl_valid), .rd_desc(rd_desc)
   );

   assign err_code = err_q;
   assign lk_valid = tbl_valid && done;
   assign lk_cls   = rd_desc.cls;
   assign lk_addr  = rd_desc.addr;
   assign lk_en    = rd_desc.en;
   assign lk_size  = rd_desc.size;
   assign lk_sattr = rd_desc.sattr;
   assign lk_mattr = rd_desc.mattr;

   // R9: the table is hidden while a parse is running
   p_hide_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !lk_valid);
   // R9: the table is hidden after an abort
   p_hide_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !lk_valid);
endmodule

// File: tb/sim_prot_table_loader.sv
module sim_prot_table_loader;
   localparam int CLK_P = 10;
   localparam int TOT   = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd_req;
   logic [8:0]  rd_addr;
   logic [7:0]  rd_data = 8'h00;
   logic        busy, done, error, lk_valid, lk_en;
   logic [1:0]  err_code, lk_cls;
   logic [4:0]  lk_id = 5'd0;
   logic [31:0] lk_addr, lk_sattr, lk_mattr;
   logic [30:0] lk_size;

   int nchk = 0, nfail = 0;
   int nreads = 0;
   logic [7:0] mem [0:511];

   int exp_err, exp_n, exp_bytes;
   logic [31:0] e_addr [TOT];
   logic [31:0] e_size [TOT];
   logic [31:0] e_sat  [TOT];
   logic [31:0] e_mat  [TOT];
   int          e_cls  [TOT];
   int          cap [3] = '{16, 4, 4};

   always #(CLK_P/2) clk = ~clk;

   prot_table_loader u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .done(done), .error(error), .err_code(err_code),
      .lk_id(lk_id), .lk_valid(lk_valid), .lk_cls(lk_cls), .lk_addr(lk_addr),
      .lk_en(lk_en), .lk_size(lk_size), .lk_sattr(lk_sattr), .lk_mattr(lk_mattr)
   );

   always @(posedge clk) if (rd_req) rd_data <= mem[rd_addr];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the model's address stream (R2) and visibility (R9)
   always @(negedge clk) if (rst_n) begin
      if (rd_req) begin
         chk(rd_addr == 9'(nreads), "R2", "read address", 64'(rd_addr), 64'(nreads));
         nreads++;
      end
      if (busy && lk_valid) chk(1'b0, "R9", "valid while busy", 64'(lk_valid), 64'd0);
   end

   function automatic logic [31:0] w32(int p);
      return {mem[p+3], mem[p+2], mem[p+1], mem[p]};
   endfunction

   task automatic put32(int p, logic [31:0] v);
      for (int i = 0; i < 4; i++) mem[p+i] = v[8*i +: 8];
   endtask

   // image builder: counts per class, one bad flash address id, header skew
   task automatic build(int nfw, int nfr, int nwr, int bad_id, int skew);
      int p, id;
      int n [3];
      n = '{nfw, nfr, nwr};
      for (int i = 0; i < 512; i++) mem[i] = 8'h00;
      p = 4; id = 0;
      for (int c = 0; c < 3; c++) begin
         put32(p, 32'(n[c])); p += 4;
         for (int k = 0; k < n[c]; k++) begin
            logic [31:0] a;
            a = (c == 0) ? 32'h1000_0000 + 32'(id) * 32'h8000 : 32'h68 + 32'(id) * 5;
            if (id == bad_id) a = a | 32'h2;
            put32(p,      a);
            put32(p + 4,  (32'(id % 2) << 31) | (32'h100 + 32'(id)));
            put32(p + 8,  32'h00FF_0007 ^ (32'(id) << 8));
            put32(p + 12, 32'h0101_0101 * 32'(id + 1));
            p += 16; id++;
         end
      end
      put32(0, 32'(p + skew));
   endtask

   task automatic model();
      int p, id;
      logic [31:0] n, a, hdr;
      exp_err = 0; id = 0; p = 4; hdr = w32(0);
      for (int c = 0; c < 3 && exp_err == 0; c++) begin
         n = w32(p); p += 4;
         if (n > 32'(cap[c])) exp_err = 1;
         else for (int k = 0; 32'(k) < n && exp_err == 0; k++) begin
            a = w32(p);
            if (c == 0 && a[1:0] != 2'b00) begin
               exp_err = 2; p += 4;
            end else begin
               e_addr[id] = a;      e_size[id] = w32(p + 4);
               e_sat[id]  = w32(p + 8); e_mat[id] = w32(p + 12);
               e_cls[id]  = c; id++; p += 16;
            end
         end
      end
      if (exp_err == 0 && 32'(p) != hdr) exp_err = 3;
      exp_n = (exp_err == 0) ? id : 0;
      exp_bytes = p;
   endtask

   task automatic run_case(input string tag, input int restart_at);
      int t;
      model();
      @(posedge clk); #1;
      nreads = 0;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      t = 0;
      while (!(done || error) && t < 5000) begin
         @(posedge clk); #1;
         t++;
         if (t == restart_at) begin
            start = 1'b1;               // R10: must be ignored
            @(posedge clk); #1;
            start = 1'b0;
         end
      end
      @(negedge clk);
      chk(done == (exp_err == 0), tag, "done", 64'(done), 64'(exp_err == 0));
      chk(error == (exp_err != 0), tag, "error", 64'(error), 64'(exp_err != 0));
      chk(err_code == 2'(exp_err), tag, "err_code", 64'(err_code), 64'(exp_err));
      chk(nreads == exp_bytes, "R2", "bytes read", 64'(nreads), 64'(exp_bytes));
      for (int id = 0; id < TOT; id++) begin
         lk_id = 5'(id); #1;
         chk(lk_valid == (id < exp_n), "R9", "lk_valid", 64'(lk_valid), 64'(id < exp_n));
         if (id < exp_n) begin
            chk(lk_addr == e_addr[id], "R3", "address", 64'(lk_addr), 64'(e_addr[id]));
            chk({lk_en, lk_size} == e_size[id], "R3", "size word",
                64'({lk_en, lk_size}), 64'(e_size[id]));
            chk({lk_sattr, lk_mattr} == {e_sat[id], e_mat[id]}, "R3", "attributes",
                {lk_sattr, lk_mattr}, {e_sat[id], e_mat[id]});
            chk(lk_cls == 2'(e_cls[id]), "R4", "class order", 64'(lk_cls), 64'(e_cls[id]));
         end
      end
      lk_id = 5'd0;
   endtask

   initial begin
      #(CLK_P * 150000);
      chk(1'b0, "WD", "watchdog expired", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk({busy, done, error, rd_req} == 4'b0, "R1", "flags", 64'({busy, done, error, rd_req}), 64'd0);
      chk(err_code == 2'd0, "R1", "err_code", 64'(err_code), 64'd0);
      chk(lk_valid == 1'b0, "R1", "lk_valid", 64'(lk_valid), 64'd0);

      build(0, 1, 1, -1, 0);  run_case("R5", 0);      // empty flash class, fuse offsets unaligned
      build(1, 1, 1, -1, 0);  run_case("R3", 0);
      build(16, 4, 4, -1, 0); run_case("R4", 0);      // full table, all capacities hit
      build(0, 0, 0, -1, 0);  run_case("R5", 0);      // R10 restart clears the full table
      build(17, 0, 0, -1, 0); run_case("R6", 0);
      build(2, 5, 0, -1, 0);  run_case("R6", 0);
      build(3, 0, 1, 1, 0);   run_case("R7", 0);
      build(1, 2, 1, -1, 1);  run_case("R8", 0);
      build(2, 1, 0, -1, -4); run_case("R8", 0);
      build(4, 2, 3, -1, 0);  run_case("R10", 40);    // start mid-parse ignored
      build(2, 0, 2, -1, 0);  run_case("R10", 0);     // fresh parse after completion

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule